// File: doc/BRIEF.md
# Token-Passing Control Primitives

This block is a kit of small control elements for building a hardware algorithm as a flowchart instead of as one encoded state machine. Control moves between elements as a token: a pulse that lasts one clock cycle. Each element takes a token in and sends a token out on the clock edge after it decides. This registered step means that every element on a path adds at least one cycle. Flowcharts are built by wiring token outputs to token inputs. One output may drive several elements to start parallel paths, and a join brings those paths back together.

The kit contains five elements:

- A two-way branch steered by a condition bit.
- A subroutine caller that starts a sub-flow and waits for its return pulse.
- An evoke unit that holds a start level to a datapath operation until that operation reports done.
- A serial merge that passes on a token from any of its inputs.
- A join that waits until every input has delivered a token.

The caller and the evoke unit each show a busy flag while they wait. A token that reaches either one while it is busy is dropped, and this latches an error flag. The top module places one of each element side by side, so each one can be wired into a larger flow. There is no data stream in this block, so there is no valid/ready interface. Every pin is a plain control or status level, or a one-cycle pulse.

Top module: `ctl_token_kit`

## Requirements
- R1: While `rst` is sampled high, and on the first cycle after it, every output is low and the error flags are clear.
- R2: A `br_go` pulse raises `br_take` on the next cycle if `br_cond` was 1, or `br_skip` if it was 0, for exactly one cycle. Without `br_go`, neither output is raised, and the two are never high together.
- R3: A `sub_go` pulse while the caller is idle gives a one-cycle `sub_call` pulse and raises `sub_busy` on the next cycle. `sub_busy` stays high until a `sub_ret` pulse is sampled. On the cycle after that, `sub_next` pulses once and `sub_busy` falls.
- R4: An `ev_go` pulse while the evoke unit is idle raises `ev_start` and `ev_busy` on the next cycle. Both stay high until `ev_done` is sampled high. On the cycle after that, both fall and `ev_next` pulses for one cycle.
- R5: A `sub_ret` or `ev_done` that arrives while its element is idle has no effect: no `sub_next` or `ev_next` pulse and no busy.
- R6: A second invocation that arrives while the caller or the evoke unit is busy is ignored: no new call or start pulse, and the pending wait finishes with a single next pulse. The same invocation sets that element's error flag (`sub_err` / `ev_err`), which stays set until reset.
- R7: The serial merge pulses `sm_out` for one cycle, one cycle after any bit of `sm_in` is high. Several bits high in the same cycle give a single pulse.
- R8: The join pulses `pm_out` for one cycle, on the cycle after the last missing bit of `pm_in` arrives. Bits may arrive in any order or all together. A repeated arrival on a bit that is already recorded does not make it fire.
- R9: When the join fires, it discards every recorded arrival, including any that came in the firing cycle. The next firing then needs a fresh arrival on every input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| br_go | input | 1 | Branch token in |
| br_cond | input | 1 | Branch condition |
| br_take | output | 1 | Token out when the condition is 1 |
| br_skip | output | 1 | Token out when the condition is 0 |
| sub_go | input | 1 | Caller token in |
| sub_ret | input | 1 | Return pulse from the sub-flow |
| sub_call | output | 1 | Token to the first element of the sub-flow |
| sub_next | output | 1 | Token to the following element |
| sub_busy | output | 1 | Caller is waiting for its return |
| sub_err | output | 1 | Sticky: caller was invoked while busy |
| ev_go | input | 1 | Evoke token in |
| ev_done | input | 1 | Completion from the datapath operation |
| ev_start | output | 1 | Start level to the datapath operation |
| ev_next | output | 1 | Token to the following element |
| ev_busy | output | 1 | Evoke unit is waiting for done |
| ev_err | output | 1 | Sticky: evoke unit was invoked while busy |
| sm_in | input | N_IN | Serial merge token inputs |
| sm_out | output | 1 | Serial merge token out |
| pm_in | input | N_IN | Join token inputs |
| pm_out | output | 1 | Join token out |

## Verification
The branch is driven with each condition value and also with no token, which shows that steering and one-hot behaviour are both correct. The waiting elements are driven in three ways:

- With return and done pulses that arrive after a delay of several cycles, which shows that the wait really holds.
- With stray completions while idle.
- With a second token while busy, which separates dropping the token from restarting the wait.

The serial merge receives a single input and then coincident inputs, which shows whether it collapses simultaneous tokens into one pulse. The join receives staggered arrivals with a duplicate, then a simultaneous arrival, then a partial arrival after a firing. This shows that it counts distinct inputs and clears its record when it fires.

// File: rtl/ctl_tok_pkg.sv
package ctl_tok_pkg;
  typedef enum logic {
    WT_IDLE = 1'b0,
    WT_WAIT = 1'b1
  } wait_st_e;
endpackage

// File: rtl/tok_branch.sv
module tok_branch (
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic cond,
  output logic take,
  output logic skip
);
  logic take_q, skip_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      take_q <= 1'b0;
      skip_q <= 1'b0;
    end else begin
      take_q <= go & cond;
      skip_q <= go & ~cond;
    end
  end

  assign take = take_q;
  assign skip = skip_q;

  a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({take, skip}));
  a_r2_needs_token: assert property (@(posedge clk) disable iff (rst)
    (take || skip) |-> $past(go));
endmodule

// File: rtl/tok_waiter.sv
module tok_waiter #(
  parameter bit HOLD_START = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic done,
  output logic launch,
  output logic next,
  output logic busy,
  output logic err
);
  import ctl_tok_pkg::*;

  wait_st_e st_q;
  logic     launch_q, next_q, err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= WT_IDLE;
      launch_q <= 1'b0;
      next_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      launch_q <= 1'b0;
      next_q   <= 1'b0;
      case (st_q)
        WT_IDLE: begin
          if (go) begin
            st_q     <= WT_WAIT;
            launch_q <= 1'b1;
          end
        end
        default: begin
          if (go) err_q <= 1'b1;
          if (done) begin
            st_q   <= WT_IDLE;
            next_q <= 1'b1;
          end
        end
      endcase
    end
  end

  assign busy = (st_q == WT_WAIT);
  assign next = next_q;
  assign err  = err_q;

  generate
    if (HOLD_START) begin : g_level
      assign launch = busy;
    end else begin : g_pulse
      assign launch = launch_q;
    end
  endgenerate

  a_r3_next_after_done: assert property (@(posedge clk) disable iff (rst)
    next |-> $past(busy && done));
  a_r5_idle_done_ignored: assert property (@(posedge clk) disable iff (rst)
    (!busy && !go) |=> !busy && !next);
  a_r6_err_on_overlap: assert property (@(posedge clk) disable iff (rst)
    (busy && go) |=> err);
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
endmodule

// File: rtl/tok_smerge.sv
module tok_smerge #(
  parameter int N_IN = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_IN-1:0] in_tok,
  output logic            out_tok
);
  logic out_q;

  always_ff @(posedge clk) begin
    if (rst) out_q <= 1'b0;
    else     out_q <= |in_tok;
  end

  assign out_tok = out_q;

  a_r7_no_spurious: assert property (@(posedge clk) disable iff (rst)
    out_tok |-> $past(in_tok != '0));
endmodule

// File: rtl/tok_join.sv
module tok_join #(
  parameter int N_IN = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_IN-1:0] in_tok,
  output logic            out_tok
);
  logic [N_IN-1:0] seen_q;
  logic [N_IN-1:0] arrived;
  logic            all_in;
  logic            fire_q;

  assign arrived = seen_q | in_tok;
  assign all_in  = &arrived;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= '0;
      fire_q <= 1'b0;
    end else if (all_in) begin
      seen_q <= '0;
      fire_q <= 1'b1;
    end else begin
      seen_q <= arrived;
      fire_q <= 1'b0;
    end
  end

  assign out_tok = fire_q;

  a_r9_clear_on_fire: assert property (@(posedge clk) disable iff (rst)
    out_tok |-> (seen_q == '0));
  a_r8_record_kept: assert property (@(posedge clk) disable iff (rst)
    (!out_tok && !$past(rst)) |-> (($past(seen_q) & ~seen_q) == '0));
endmodule

// File: rtl/ctl_token_kit.sv
module ctl_token_kit #(
  parameter int N_IN = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            br_go,
  input  logic            br_cond,
  output logic            br_take,
  output logic            br_skip,
  input  logic            sub_go,
  input  logic            sub_ret,
  output logic            sub_call,
  output logic            sub_next,
  output logic            sub_busy,
  output logic            sub_err,
  input  logic            ev_go,
  input  logic            ev_done,
  output logic            ev_start,
  output logic            ev_next,
  output logic            ev_busy,
  output logic            ev_err,
  input  logic [N_IN-1:0] sm_in,
  output logic            sm_out,
  input  logic [N_IN-1:0] pm_in,
  output logic            pm_out
);
  tok_branch u_br (
    .clk(clk), .rst(rst), .go(br_go), .cond(br_cond),
    .take(br_take), .skip(br_skip)
  );

  tok_waiter #(.HOLD_START(1'b0)) u_sub (
    .clk(clk), .rst(rst), .go(sub_go), .done(sub_ret),
    .launch(sub_call), .next(sub_next), .busy(sub_busy), .err(sub_err)
  );

  tok_waiter #(.HOLD_START(1'b1)) u_ev (
    .clk(clk), .rst(rst), .go(ev_go), .done(ev_done),
    .launch(ev_start), .next(ev_next), .busy(ev_busy), .err(ev_err)
  );

  tok_smerge #(.N_IN(N_IN)) u_sm (
    .clk(clk), .rst(rst), .in_tok(sm_in), .out_tok(sm_out)
  );

  tok_join #(.N_IN(N_IN)) u_pm (
    .clk(clk), .rst(rst), .in_tok(pm_in), .out_tok(pm_out)
  );

  a_r4_start_tracks_busy: assert property (@(posedge clk) disable iff (rst)
    ev_start == ev_busy);
  a_r1_post_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> !(br_take || br_skip || sub_call || sub_next || ev_next
                     || sm_out || pm_out || sub_err || ev_err));
endmodule

// File: tb/sim_ctl_token_kit.sv
`timescale 1ns/1ps
module sim_ctl_token_kit;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rst;
  logic br_go, br_cond, br_take, br_skip;
  logic sub_go, sub_ret, sub_call, sub_next, sub_busy, sub_err;
  logic ev_go, ev_done, ev_start, ev_next, ev_busy, ev_err;
  logic [N-1:0] sm_in, pm_in;
  logic sm_out, pm_out;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  ctl_token_kit #(.N_IN(N)) u0 (
    .clk(clk), .rst(rst),
    .br_go(br_go), .br_cond(br_cond), .br_take(br_take), .br_skip(br_skip),
    .sub_go(sub_go), .sub_ret(sub_ret), .sub_call(sub_call),
    .sub_next(sub_next), .sub_busy(sub_busy), .sub_err(sub_err),
    .ev_go(ev_go), .ev_done(ev_done), .ev_start(ev_start),
    .ev_next(ev_next), .ev_busy(ev_busy), .ev_err(ev_err),
    .sm_in(sm_in), .sm_out(sm_out), .pm_in(pm_in), .pm_out(pm_out)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    br_go = 0; br_cond = 0; sub_go = 0; sub_ret = 0;
    ev_go = 0; ev_done = 0; sm_in = '0; pm_in = '0;
    repeat (3) step();
    rst = 1'b0;
  endtask

  // R1
  task automatic t_reset();
    do_reset();
    chk("R1 br", br_take | br_skip, 1'b0);
    chk("R1 sub", sub_call | sub_next | sub_busy | sub_err, 1'b0);
    chk("R1 ev", ev_start | ev_next | ev_busy | ev_err, 1'b0);
    chk("R1 merges", sm_out | pm_out, 1'b0);
  endtask

  // R2
  task automatic t_branch();
    br_go = 1; br_cond = 1; step();
    br_go = 0;
    chk("R2 take", br_take, 1'b1); chk("R2 no skip", br_skip, 1'b0);
    step();
    chk("R2 take one cycle", br_take, 1'b0);
    br_go = 1; br_cond = 0; step();
    br_go = 0; br_cond = 1;
    chk("R2 skip", br_skip, 1'b1); chk("R2 no take", br_take, 1'b0);
    step();
    chk("R2 idle", br_take | br_skip, 1'b0);
  endtask

  // R3, R5
  task automatic t_sub();
    sub_ret = 1; step(); sub_ret = 0;
    chk("R5 stray ret", sub_next | sub_busy, 1'b0);
    sub_go = 1; step(); sub_go = 0;
    chk("R3 call", sub_call, 1'b1); chk("R3 busy", sub_busy, 1'b1);
    step();
    chk("R3 call one cycle", sub_call, 1'b0);
    repeat (3) step();
    chk("R3 still busy", sub_busy, 1'b1); chk("R3 no early next", sub_next, 1'b0);
    sub_ret = 1; step(); sub_ret = 0;
    chk("R3 next", sub_next, 1'b1); chk("R3 busy clear", sub_busy, 1'b0);
    step();
    chk("R3 next one cycle", sub_next, 1'b0);
    chk("R6 no err yet", sub_err, 1'b0);
  endtask

  // R4, R5
  task automatic t_evoke();
    ev_done = 1; step(); ev_done = 0;
    chk("R5 stray done", ev_next | ev_busy, 1'b0);
    ev_go = 1; step(); ev_go = 0;
    chk("R4 start", ev_start, 1'b1); chk("R4 busy", ev_busy, 1'b1);
    repeat (3) step();
    chk("R4 start held", ev_start, 1'b1); chk("R4 no early next", ev_next, 1'b0);
    ev_done = 1; step(); ev_done = 0;
    chk("R4 start drop", ev_start, 1'b0); chk("R4 next", ev_next, 1'b1);
    step();
    chk("R4 next one cycle", ev_next, 1'b0);
  endtask

  // R6
  task automatic t_overlap();
    int nexts = 0;
    sub_go = 1; ev_go = 1; step();
    step();
    sub_go = 1; ev_go = 1; step(); sub_go = 0; ev_go = 0;
    chk("R6 no recall", sub_call, 1'b0);
    chk("R6 sub err", sub_err, 1'b1); chk("R6 ev err", ev_err, 1'b1);
    chk("R6 still busy", sub_busy, 1'b1);
    sub_ret = 1; ev_done = 1; step(); sub_ret = 0; ev_done = 0;
    if (sub_next) nexts++;
    chk("R6 ev next", ev_next, 1'b1);
    for (int i = 0; i < 3; i++) begin
      step();
      if (sub_next) nexts++;
    end
    chk("R6 single next", nexts == 1, 1'b1);
    chk("R6 idle after", sub_busy | ev_busy, 1'b0);
    chk("R6 sub err sticky", sub_err, 1'b1);
    chk("R6 ev err sticky", ev_err, 1'b1);
    do_reset();
    chk("R6 err cleared by reset", sub_err | ev_err, 1'b0);
  endtask

  // R7
  task automatic t_smerge();
    sm_in = 3'b010; step(); sm_in = '0;
    chk("R7 single", sm_out, 1'b1);
    step();
    chk("R7 one cycle", sm_out, 1'b0);
    sm_in = 3'b111; step(); sm_in = '0;
    chk("R7 coincident", sm_out, 1'b1);
    step();
    chk("R7 coincident single pulse", sm_out, 1'b0);
  endtask

  // R8, R9
  task automatic t_join();
    pm_in = 3'b001; step(); pm_in = '0;
    chk("R8 partial", pm_out, 1'b0);
    pm_in = 3'b100; step();
    pm_in = 3'b001; step(); pm_in = '0;
    chk("R8 duplicate no fire", pm_out, 1'b0);
    step();
    pm_in = 3'b010; step(); pm_in = '0;
    chk("R8 fires on last", pm_out, 1'b1);
    step();
    chk("R8 one cycle", pm_out, 1'b0);
    pm_in = 3'b111; step(); pm_in = '0;
    chk("R8 all together", pm_out, 1'b1);
    pm_in = 3'b011; step(); pm_in = '0;
    chk("R9 after fire partial", pm_out, 1'b0);
    pm_in = 3'b100; step(); pm_in = '0;
    chk("R9 needs fresh all", pm_out, 1'b1);
    step();
    pm_in = 3'b110; step(); pm_in = '0;
    chk("R9 cleared record", pm_out, 1'b0);
    pm_in = 3'b001; step(); pm_in = '0;
    chk("R9 completes", pm_out, 1'b1);
  endtask

  logic fin = 1'b0;

  initial begin
    #400000;
    if (!fin) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_branch();
    t_sub();
    t_evoke();
    t_overlap();
    t_smerge();
    t_join();
    fin = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule